// File: doc/BRIEF.md
# Serial Audio Input Receiver

This block accepts a two-channel serial audio stream as a slave. The stream arrives on three wires: a bit clock, a frame clock that tells the left channel from the right, and a data line. All three are brought into the much faster system clock domain through two-flop synchronizers, and the chosen bit-clock edge is found there. The block turns each stereo frame into a pair of parallel 24-bit words, left and right, and raises a one-cycle valid strobe when the pair is ready. The system clock must run at least four times as fast as the bit clock.

Static configuration inputs choose how the bits are laid out. Data can be left-justified, where the MSB follows the frame-clock change, either at once or one bit period later. Data can also be right-justified, where the LSB is the last bit before the next frame-clock change, with 16, 20 or 24 significant bits. The other inputs select which bit-clock edge samples the data, which frame-clock level marks the left channel, and whether a stereo frame has 64 or 128 bit periods. Samples arrive MSB first. Shorter samples are returned left-aligned and padded with zeros below.

A four-state machine tracks the stream. ST_IDLE leaves on the first sampling edge (T_FIRST_EDGE) and enters ST_HUNT. ST_HUNT waits for a right-to-left half-frame change (T_LOCK) and then enters ST_LEFT. ST_LEFT moves to ST_RIGHT at the next left-to-right change (T_LEFT_DONE), holding the left word. ST_RIGHT returns to ST_LEFT at the next right-to-left change (T_FRAME_DONE), which publishes both words and the strobe. Each state stays put in any cycle without its transition.

Top module: `ser_aud_rx`

## Requirements
- R1: After reset, valid_o is 0 and left_o and right_o are all zeros.
- R2: With cfg_rjust=0 and cfg_delay=0, the bit sampled at the first sampling edge after a frame-clock change is the MSB, and the next 23 bits complete the 24-bit word.
- R3: With cfg_rjust=0 and cfg_delay=1, the MSB is the bit sampled at the second sampling edge after a frame-clock change.
- R4: In left-justified mode, bits after the 24th sample bit of a half-frame have no effect on the output word.
- R5: With cfg_rjust=1, cfg_res selects 24 (00), 20 (01) or 16 (10) bits. Only the last N bits before the next frame-clock change are kept. They are returned left-aligned with zeros in the low 24-N bits, and earlier bits of the half-frame have no effect.
- R6: cfg_fall_edge=0 samples the data and frame clock on rising bit-clock edges, and 1 samples them on falling edges.
- R7: cfg_lr_inv=0 makes a high frame clock the left channel, and 1 makes a high frame clock the right channel.
- R8: cfg_bpf128=0 gives 64 bit periods per stereo frame (32 per channel), and 1 gives 128 (64 per channel). The right-justified sample window is placed at the end of the half-frame of that length.
- R9: valid_o is high for exactly one system cycle, once per frame, when the right half-frame ends (the first sampling edge of the following left half). left_o and right_o change only in that cycle, and they stay stable between strobes.
- R10: After reset, no valid strobe is produced until a complete left half-frame and a complete right half-frame have been received, where the left half began at an observed right-to-left change.
- R11: In right-justified mode, the reserved resolution code 11 behaves as 24 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bclk_i | input | 1 | Serial bit clock (asynchronous) |
| lrck_i | input | 1 | Frame clock, left/right select (asynchronous) |
| sdata_i | input | 1 | Serial data (asynchronous) |
| cfg_rjust | input | 1 | 0 left-justified, 1 right-justified |
| cfg_delay | input | 1 | Left-justified MSB delay: 0 none, 1 one bit period |
| cfg_fall_edge | input | 1 | 0 sample on rising bit-clock edge, 1 on falling |
| cfg_lr_inv | input | 1 | 0 high frame clock means left, 1 means right |
| cfg_res | input | 2 | Right-justified resolution: 00 24, 01 20, 10 16, 11 24 |
| cfg_bpf128 | input | 1 | 0 64 bit periods per frame, 1 128 |
| left_o | output | 24 | Left-channel sample, left-aligned |
| right_o | output | 24 | Right-channel sample, left-aligned |
| valid_o | output | 1 | One-cycle strobe when a sample pair is ready |

## Verification
An error in the bit-index counter or the capture window shows up as a sample shifted by one or more bit positions. For the right-justified layouts, it instead shows up as leftover bits below the significant ones, and it appears at the very next strobe. If the state machine enters the wrong state, the strobe comes one half-frame early or late, or with the channels swapped. This first shows at the end of the next full frame, which is at most 128 bit periods away. A synchronizer or edge-select fault makes every bit slip or come from the wrong half-period, so the first pair of words after the fault is already wrong.

// File: rtl/sarx_pkg.sv
package sarx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_HUNT,
        ST_LEFT,
        ST_RIGHT
    } sarx_state_e;

    localparam logic [1:0] RES_CODE_24 = 2'b00;
    localparam logic [1:0] RES_CODE_20 = 2'b01;
    localparam logic [1:0] RES_CODE_16 = 2'b10;

    // Significant bits for a right-justified resolution code; the reserved code maps to 24.
    function automatic int unsigned res_bits(input logic [1:0] code);
        case (code)
            RES_CODE_20: return 20;
            RES_CODE_16: return 16;
            default:     return 24;
        endcase
    endfunction

endpackage

// File: rtl/sarx_sync.sv
module sarx_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q[0] <= '0;
        end else begin
            stage_q[0] <= async_i;
        end
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stage_q[s] <= '0;
            end else begin
                stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/sarx_sampler.sv
module sarx_sampler (
    input  logic clk,
    input  logic rst_n,
    input  logic bclk_s,
    input  logic lrck_s,
    input  logic sdata_s,
    input  logic cfg_fall_edge,
    input  logic cfg_lr_inv,
    output logic stb_o,
    output logic bit_o,
    output logic right_o
);

    logic bclk_prev_q;
    logic edge_hit;
    logic is_right;

    // Pick the configured bit-clock edge.
    assign edge_hit = cfg_fall_edge ? (bclk_prev_q & ~bclk_s) : (~bclk_prev_q & bclk_s);
    // Polarity 0: a high frame clock is left, so right means low.
    assign is_right = lrck_s ^ ~cfg_lr_inv;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bclk_prev_q <= 1'b0;
            stb_o       <= 1'b0;
            bit_o       <= 1'b0;
            right_o     <= 1'b0;
        end else begin
            bclk_prev_q <= bclk_s;
            stb_o       <= edge_hit;
            if (edge_hit) begin
                bit_o   <= sdata_s;
                right_o <= is_right;
            end
        end
    end

    // R6: one strobe per selected edge, never on two adjacent cycles
    a_r6_strobe_isolated: assert property (@(posedge clk) disable iff (!rst_n)
        stb_o |=> !stb_o);

endmodule

// File: rtl/sarx_capture.sv
module sarx_capture #(
    parameter int SAMPLE_W      = 24,
    parameter int FRAME_BCLK_LO = 64,
    parameter int FRAME_BCLK_HI = 128
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                stb_i,
    input  logic                bit_i,
    input  logic                right_i,
    input  logic                cfg_rjust,
    input  logic                cfg_delay,
    input  logic [1:0]          cfg_res,
    input  logic                cfg_bpf128,
    output logic                bnd_o,
    output logic                bnd_right_o,
    output logic [SAMPLE_W-1:0] word_o
);

    localparam int IDX_W = $clog2(FRAME_BCLK_HI);
    localparam int LIM_W = IDX_W + 1;
    localparam int CAP_W = $clog2(SAMPLE_W + 1);

    logic                seen_q;
    logic                prev_right_q;
    logic [IDX_W-1:0]    idx_q;
    logic [SAMPLE_W-1:0] shreg_q;
    logic [CAP_W-1:0]    cap_q;

    logic                boundary;
    logic [IDX_W-1:0]    idx_now;
    logic [CAP_W-1:0]    cap_now;
    logic [LIM_W-1:0]    half_len;
    logic [LIM_W-1:0]    nbits;
    logic [LIM_W-1:0]    win_lo;
    logic [LIM_W-1:0]    win_hi;
    logic                in_win;
    logic [CAP_W-1:0]    shamt;
    logic [SAMPLE_W-1:0] aligned;

    assign boundary = stb_i & seen_q & (right_i != prev_right_q);
    assign idx_now  = boundary ? '0 : idx_q;
    assign cap_now  = boundary ? '0 : cap_q;

    assign half_len = cfg_bpf128 ? LIM_W'(FRAME_BCLK_HI / 2) : LIM_W'(FRAME_BCLK_LO / 2);
    assign nbits    = cfg_rjust ? LIM_W'(sarx_pkg::res_bits(cfg_res)) : LIM_W'(SAMPLE_W);

    // Window of bit indices that carry the sample in this half-frame.
    always_comb begin
        if (cfg_rjust) begin
            win_lo = half_len - nbits;
            win_hi = half_len;
        end else begin
            win_lo = {{(LIM_W-1){1'b0}}, cfg_delay};
            win_hi = {{(LIM_W-1){1'b0}}, cfg_delay} + LIM_W'(SAMPLE_W);
        end
    end

    assign in_win = ({1'b0, idx_now} >= win_lo) && ({1'b0, idx_now} < win_hi)
                  && (cap_now < CAP_W'(SAMPLE_W));

    assign shamt   = CAP_W'(SAMPLE_W) - cap_q;
    assign aligned = shreg_q << shamt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_q       <= 1'b0;
            prev_right_q <= 1'b0;
            idx_q        <= '0;
            shreg_q      <= '0;
            cap_q        <= '0;
            bnd_o        <= 1'b0;
            bnd_right_o  <= 1'b0;
            word_o       <= '0;
        end else begin
            bnd_o <= 1'b0;
            if (stb_i) begin
                seen_q       <= 1'b1;
                prev_right_q <= right_i;
                if (idx_now != {IDX_W{1'b1}}) begin
                    idx_q <= idx_now + 1'b1;
                end
                if (boundary) begin
                    bnd_o       <= 1'b1;
                    bnd_right_o <= right_i;
                    word_o      <= aligned;
                    shreg_q     <= in_win ? {{(SAMPLE_W-1){1'b0}}, bit_i} : '0;
                    cap_q       <= in_win ? CAP_W'(1) : '0;
                end else if (in_win) begin
                    shreg_q <= {shreg_q[SAMPLE_W-2:0], bit_i};
                    cap_q   <= cap_q + 1'b1;
                end
            end
        end
    end

    // R5: never more significant bits collected than the word holds
    a_r5_cap_limit: assert property (@(posedge clk) disable iff (!rst_n)
        cap_q <= CAP_W'(SAMPLE_W));

    // R2: a half-frame boundary is only reported after a sampling strobe
    a_r2_bnd_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        bnd_o |-> $past(stb_i));

endmodule

// File: rtl/sarx_fsm.sv
module sarx_fsm #(
    parameter int SAMPLE_W = 24
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                stb_i,
    input  logic                bnd_i,
    input  logic                bnd_right_i,
    input  logic [SAMPLE_W-1:0] word_i,
    output logic [SAMPLE_W-1:0] left_o,
    output logic [SAMPLE_W-1:0] right_o,
    output logic                valid_o
);

    import sarx_pkg::*;

    sarx_state_e         state_q;
    sarx_state_e         state_d;
    logic [SAMPLE_W-1:0] left_hold_q;
    logic                t_left_done;
    logic                t_frame_done;

    always_comb begin
        state_d      = state_q;
        t_left_done  = 1'b0;
        t_frame_done = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (stb_i) state_d = ST_HUNT;             // T_FIRST_EDGE
            end
            ST_HUNT: begin
                if (bnd_i && !bnd_right_i) state_d = ST_LEFT;   // T_LOCK
            end
            ST_LEFT: begin
                if (bnd_i && bnd_right_i) begin           // T_LEFT_DONE
                    state_d     = ST_RIGHT;
                    t_left_done = 1'b1;
                end
            end
            ST_RIGHT: begin
                if (bnd_i && !bnd_right_i) begin          // T_FRAME_DONE
                    state_d      = ST_LEFT;
                    t_frame_done = 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            left_hold_q <= '0;
            left_o      <= '0;
            right_o     <= '0;
            valid_o     <= 1'b0;
        end else begin
            valid_o <= t_frame_done;
            if (t_left_done) begin
                left_hold_q <= word_i;
            end
            if (t_frame_done) begin
                left_o  <= left_hold_q;
                right_o <= word_i;
            end
        end
    end

    // R9: strobe lasts exactly one cycle
    a_r9_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

    // R10: a strobe only ever follows a completed right half-frame
    a_r10_valid_after_right: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> ($past(state_q) == ST_RIGHT));

    // R9: output words move only together with the strobe
    a_r9_left_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(left_o) |-> valid_o);

    a_r9_right_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(right_o) |-> valid_o);

endmodule

// File: rtl/ser_aud_rx.sv
module ser_aud_rx #(
    parameter int SAMPLE_W      = 24,
    parameter int SYNC_STAGES   = 2,
    parameter int FRAME_BCLK_LO = 64,
    parameter int FRAME_BCLK_HI = 128
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bclk_i,
    input  logic                lrck_i,
    input  logic                sdata_i,
    input  logic                cfg_rjust,
    input  logic                cfg_delay,
    input  logic                cfg_fall_edge,
    input  logic                cfg_lr_inv,
    input  logic [1:0]          cfg_res,
    input  logic                cfg_bpf128,
    output logic [SAMPLE_W-1:0] left_o,
    output logic [SAMPLE_W-1:0] right_o,
    output logic                valid_o
);

    localparam int N_SYNC = 3;

    logic [N_SYNC-1:0]   pins_s;
    logic                stb;
    logic                bit_v;
    logic                right_v;
    logic                bnd;
    logic                bnd_right;
    logic [SAMPLE_W-1:0] word;

    sarx_sync #(
        .WIDTH  (N_SYNC),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({sdata_i, lrck_i, bclk_i}),
        .sync_o  (pins_s)
    );

    sarx_sampler u_sampler (
        .clk           (clk),
        .rst_n         (rst_n),
        .bclk_s        (pins_s[0]),
        .lrck_s        (pins_s[1]),
        .sdata_s       (pins_s[2]),
        .cfg_fall_edge (cfg_fall_edge),
        .cfg_lr_inv    (cfg_lr_inv),
        .stb_o         (stb),
        .bit_o         (bit_v),
        .right_o       (right_v)
    );

    sarx_capture #(
        .SAMPLE_W      (SAMPLE_W),
        .FRAME_BCLK_LO (FRAME_BCLK_LO),
        .FRAME_BCLK_HI (FRAME_BCLK_HI)
    ) u_capture (
        .clk         (clk),
        .rst_n       (rst_n),
        .stb_i       (stb),
        .bit_i       (bit_v),
        .right_i     (right_v),
        .cfg_rjust   (cfg_rjust),
        .cfg_delay   (cfg_delay),
        .cfg_res     (cfg_res),
        .cfg_bpf128  (cfg_bpf128),
        .bnd_o       (bnd),
        .bnd_right_o (bnd_right),
        .word_o      (word)
    );

    sarx_fsm #(
        .SAMPLE_W (SAMPLE_W)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .stb_i       (stb),
        .bnd_i       (bnd),
        .bnd_right_i (bnd_right),
        .word_i      (word),
        .left_o      (left_o),
        .right_o     (right_o),
        .valid_o     (valid_o)
    );

endmodule

// File: tb/sim_ser_aud_rx.sv
module sim_ser_aud_rx;

    typedef struct packed {
        logic [23:0] l;
        logic [23:0] r;
    } pair_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bclk = 1'b0, lrck = 1'b0, sdata = 1'b0;
    logic        cfg_rjust = 1'b0, cfg_delay = 1'b0, cfg_fall = 1'b0, cfg_inv = 1'b0, cfg_r128 = 1'b0;
    logic [1:0]  cfg_res = 2'b00;
    logic [23:0] left_o, right_o;
    logic        valid_o;

    int    checks = 0;
    int    failures = 0;
    int    vcount = 0;
    bit    prev_v = 1'b0;
    bit    done = 1'b0;
    string tag = "R1";
    pair_t expq[$];

    always #10 clk = ~clk;

    ser_aud_rx u0 (
        .clk (clk), .rst_n (rst_n), .bclk_i (bclk), .lrck_i (lrck), .sdata_i (sdata),
        .cfg_rjust (cfg_rjust), .cfg_delay (cfg_delay), .cfg_fall_edge (cfg_fall),
        .cfg_lr_inv (cfg_inv), .cfg_res (cfg_res), .cfg_bpf128 (cfg_r128),
        .left_o (left_o), .right_o (right_o), .valid_o (valid_o)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [23:0] act, input logic [23:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Scoreboard monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_v && valid_o)
                check(1'b0, "R9", "strobe wider than one cycle", 24'd1, 24'd0);
            if (valid_o) begin
                vcount++;
                if (expq.size() == 0) begin
                    check(1'b0, "R10", "unexpected strobe", 24'd1, 24'd0);
                end else begin
                    pair_t e;
                    e = expq.pop_front();
                    check(left_o == e.l, tag, "left word", left_o, e.l);
                    check(right_o == e.r, tag, "right word", right_o, e.r);
                end
            end
        end
        prev_v = valid_o;
    end

    function automatic int nres();
        if (!cfg_rjust) return 24;
        case (cfg_res)
            2'b01: return 20;
            2'b10: return 16;
            default: return 24;
        endcase
    endfunction

    function automatic logic [23:0] expect_word(input logic [23:0] s);
        return s & (24'hFFFFFF << (24 - nres()));
    endfunction

    // One bit period: launch edge carries new data/frame clock, then the sampling edge.
    task automatic drive_slot(input bit is_left, input logic d);
        @(negedge clk);
        bclk  = cfg_fall;
        lrck  = is_left ^ cfg_inv;
        sdata = d;
        repeat (4) @(negedge clk);
        bclk = ~cfg_fall;
        repeat (3) @(negedge clk);
    endtask

    task automatic drive_half(input bit is_left, input logic [23:0] s, input int nslots);
        int half = cfg_r128 ? 64 : 32;
        int n    = nres();
        int lo   = cfg_rjust ? half - n : int'(cfg_delay);
        for (int k = 0; k < nslots; k++) begin
            logic b;
            if (k >= lo && k < lo + n) b = s[23 - (k - lo)];
            else b = 1'($urandom_range(0, 1));
            drive_slot(is_left, b);
        end
    endtask

    task automatic run_group(input bit rj, input bit dly, input bit fall, input bit inv,
                             input logic [1:0] res, input bit r128, input string t);
        int half;
        rst_n = 1'b0;
        cfg_rjust = rj; cfg_delay = dly; cfg_fall = fall; cfg_inv = inv;
        cfg_res = res; cfg_r128 = r128;
        bclk = fall; lrck = 1'b0; sdata = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        tag = t;
        half = r128 ? 64 : 32;
        vcount = 0;
        // Lead-in: partial left then full right half of noise
        drive_half(1'b1, 24'h0, 5);
        drive_half(1'b0, 24'h0, half);
        check(vcount == 0, "R10", "strobe before first full frame", 24'(vcount), 24'd0);
        for (int f = 0; f < 3; f++) begin
            pair_t e;
            logic [23:0] ls = 24'($urandom);
            logic [23:0] rs = 24'($urandom);
            e.l = expect_word(ls);
            e.r = expect_word(rs);
            expq.push_back(e);
            drive_half(1'b1, ls, half);
            drive_half(1'b0, rs, half);
        end
        drive_half(1'b1, 24'h0, 4);
        repeat (20) @(negedge clk);
        check(expq.size() == 0, "R9", "frames not delivered", 24'(expq.size()), 24'd0);
        expq.delete();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(valid_o == 1'b0, "R1", "valid in reset", {23'd0, valid_o}, 24'd0);
        check(left_o == 24'd0, "R1", "left in reset", left_o, 24'd0);
        check(right_o == 24'd0, "R1", "right in reset", right_o, 24'd0);
        run_group(1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 1'b0, "R2 R4 R9");
        run_group(1'b0, 1'b1, 1'b1, 1'b0, 2'b00, 1'b0, "R3 R6");
        run_group(1'b0, 1'b1, 1'b0, 1'b1, 2'b00, 1'b1, "R7 R8");
        run_group(1'b1, 1'b0, 1'b0, 1'b0, 2'b00, 1'b0, "R5 res24");
        run_group(1'b1, 1'b0, 1'b1, 1'b0, 2'b01, 1'b1, "R5 res20 R6 R8");
        run_group(1'b1, 1'b0, 1'b0, 1'b1, 2'b10, 1'b0, "R5 res16 R7");
        run_group(1'b1, 1'b1, 1'b0, 1'b0, 2'b11, 1'b0, "R11");
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule